// File: doc/BRIEF.md
# Spectral Tuple Huffman Packer

This block turns a stream of signed, already-quantized spectral coefficients into variable-length codewords. It groups the coefficients into tuples of two or four, taking them in the order they arrive (low to high frequency). It forms a table index from the tuple's magnitudes and looks up a codeword in one of four small codebooks. After the codeword it appends one sign bit for every nonzero coefficient. Each codebook stores magnitudes only. The codebook also fixes the tuple size and the largest magnitude that the tuple may hold. Each magnitude limit has two codebooks with different code-length profiles: a steep one that gives short codes to small indices, and a flat one.

The result is handed to a downstream bit packer as a bit count and a left-aligned bit field, under a valid/ready handshake. A tuple that holds a magnitude the selected codebook cannot represent produces no output. Instead it raises a one-cycle error pulse, so that the controller can pick a larger codebook or route the data to an escape path. The asynchronous reset is released through a two-stage synchronizer.

Top module: `stc_tuple_coder`

## Requirements
- R1: The codebook number on `in_book` is taken with the first coefficient of each tuple. Books 0 and 1 take tuples of four coefficients with a magnitude limit of 1. Books 2 and 3 take tuples of two coefficients with a magnitude limit of 3. The value on `in_book` while the later coefficients of a tuple are accepted has no effect.
- R2: The first accepted coefficient of a tuple is position 0. For four-coefficient tuples, the index is a 4-bit word whose most significant bit is the nonzero flag of position 0, down to position 3 in the least significant bit. For two-coefficient tuples, the index is 4·|c0| + |c1|.
- R3: In books 0 and 2, the codeword for index k is k one-bits followed by a single zero-bit, so its length is k+1 (at most 16).
- R4: In books 1 and 3, the codeword is the 4-bit index sent most significant bit first.
- R5: Directly after the codeword comes one sign bit for each nonzero coefficient, in tuple position order, with 1 meaning negative. Zero coefficients add no bit.
- R6: `out_len` equals the codeword length plus the number of sign bits. The bits occupy the top `out_len` positions of `out_bits`, first bit at bit 19, and every lower bit is 0.
- R7: If any coefficient of a tuple has a magnitude above the book's limit (including -128), `range_err` is high for exactly one cycle and no output word is produced for that tuple. The next tuple is then handled normally.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_len` and `out_bits` hold their values.
- R9: In reset, `out_valid` and `range_err` are 0 and `in_ready` is 1. In the cycle after the last coefficient of a tuple is accepted, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Coefficient can be accepted |
| in_coef | input | 8 | Signed two's-complement coefficient |
| in_book | input | 2 | Codebook number, sampled with each tuple's first coefficient |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_len | output | 5 | Number of valid bits, 1 to 20 |
| out_bits | output | 20 | Codeword plus sign bits, left-aligned |
| range_err | output | 1 | One-cycle pulse: tuple exceeded its codebook limit and was dropped |

## Verification
The bench changes `in_book` in the middle of tuples. A design that re-read the book per coefficient would then switch between tuple sizes and get out of step with every following tuple. It drives the extreme indices: the all-zero tuple, whose code is a single 0 bit, and index 15 in the steep book, whose 16-bit code together with four signs fills all 20 bits. A width or shift slip at those indices would cut bits or shift them. It feeds magnitudes one above the limit and the value -128, whose magnitude does not fit in the coefficient width. A design that took the absolute value only within the coefficient width would see 0 there and emit a wrong code instead of the error pulse. Random back-pressure checks that an error tuple neither takes the output slot nor disturbs a word that is still waiting.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;
  localparam int COEF_W    = 8;
  localparam int TUPLE_MAX = 4;
  localparam int MAG_W     = 2;
  localparam int IDX_W     = 4;
  localparam int CODE_W    = 16;
  localparam int BOOK_W    = 2;

  // Books with bit 1 clear take four-coefficient tuples
  function automatic logic book_quad(input logic [BOOK_W-1:0] b);
    return ~b[1];
  endfunction

  function automatic int book_size(input logic [BOOK_W-1:0] b);
    return b[1] ? 2 : 4;
  endfunction

  function automatic logic [MAG_W-1:0] book_limit(input logic [BOOK_W-1:0] b);
    return b[1] ? MAG_W'(3) : MAG_W'(1);
  endfunction
endpackage

// File: rtl/stc_tuple_asm.sv
`timescale 1ns/1ps
module stc_tuple_asm
  import stc_pkg::*;
#(
  parameter int CW = COEF_W,
  parameter int TN = TUPLE_MAX,
  parameter int MW = MAG_W,
  parameter int BW = BOOK_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CW-1:0]          in_coef,
  input  logic [BW-1:0]          in_book,
  input  logic                   take,
  output logic                   full,
  output logic [BW-1:0]          t_book,
  output logic [TN-1:0][MW-1:0]  t_mag,
  output logic [TN-1:0]          t_neg,
  output logic                   t_over
);
  localparam int CNT_W = (TN > 1) ? $clog2(TN) : 1;

  logic [CNT_W-1:0]         cnt_q, cnt_d;
  logic                     full_q, full_d;
  logic [BW-1:0]            book_q, book_d;
  logic [TN-1:0][MW-1:0]    mag_q, mag_d;
  logic [TN-1:0]            neg_q, neg_d;
  logic                     over_q, over_d;

  logic                     accept, first, last, ovf;
  logic [BW-1:0]            cur_book;
  logic [CW:0]              ext, abs_w;

  assign accept   = in_valid && !full_q;
  assign first    = (cnt_q == '0);
  assign cur_book = first ? in_book : book_q;

  always_comb begin
    ext   = {in_coef[CW-1], in_coef};
    abs_w = in_coef[CW-1] ? (~ext + 1'b1) : ext;
    ovf   = abs_w > {{(CW+1-MW){1'b0}}, book_limit(cur_book)};
    last  = (int'(cnt_q) + 1) == book_size(cur_book);
  end

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    book_d = book_q;
    mag_d  = mag_q;
    neg_d  = neg_q;
    over_d = over_q;
    if (take) begin
      full_d = 1'b0;
    end
    if (accept) begin
      if (first) begin
        mag_d  = '0;
        neg_d  = '0;
        over_d = 1'b0;
        book_d = in_book;
      end
      mag_d[cnt_q] = abs_w[MW-1:0];
      neg_d[cnt_q] = in_coef[CW-1];
      over_d       = over_d | ovf;
      if (last) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      book_q <= '0;
      mag_q  <= '0;
      neg_q  <= '0;
      over_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        cnt_q  <= cnt_d;
        book_q <= book_d;
        mag_q  <= mag_d;
        neg_q  <= neg_d;
        over_q <= over_d;
      end
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign t_book   = book_q;
  assign t_mag    = mag_q;
  assign t_neg    = neg_q;
  assign t_over   = over_q;

  // R1: a partly filled tuple never reaches its book's size
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (int'(cnt_q) < book_size(book_q)));

  // R1: the book stays fixed once a tuple has started
  a_r1_book_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(book_q));

  // R9: a waiting tuple is neither lost nor overwritten
  a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(mag_q) && $stable(neg_q)));
endmodule

// File: rtl/stc_codebook.sv
`timescale 1ns/1ps
module stc_codebook #(
  parameter int BW = 2,
  parameter int IW = 4,
  parameter int KW = 16,
  parameter int LW = 5
) (
  input  logic [BW-1:0] book,
  input  logic [IW-1:0] idx,
  output logic [KW-1:0] code,
  output logic [LW-1:0] code_len
);
  localparam int NB = 1 << BW;

  logic [KW-1:0] tab_code [NB];
  logic [LW-1:0] tab_len  [NB];

  for (genvar g = 0; g < NB; g++) begin : g_book
    if (g % 2 == 1) begin : g_flat
      // fixed-length code: the index itself
      assign tab_code[g] = {idx, {(KW-IW){1'b0}}};
      assign tab_len[g]  = LW'(IW);
    end else begin : g_steep
      // k ones then a terminating zero, left-aligned
      assign tab_code[g] = ~({KW{1'b1}} >> idx);
      assign tab_len[g]  = LW'(idx) + LW'(1);
    end
  end

  assign code     = tab_code[book];
  assign code_len = tab_len[book];

  always_comb begin
    // R3: every codeword is between 1 and KW bits long
    a_r3_len_range: assert (code_len >= LW'(1) && code_len <= LW'(KW));
    // R6: nothing is set below the codeword
    a_r6_code_tail: assert ((code << code_len) == '0);
  end
endmodule

// File: rtl/stc_sign_merge.sv
`timescale 1ns/1ps
module stc_sign_merge #(
  parameter int TN = 4,
  parameter int MW = 2,
  parameter int KW = 16,
  parameter int LW = 5,
  parameter int FW = KW + TN
) (
  input  logic                  quad,
  input  logic [TN-1:0][MW-1:0] mag,
  input  logic [TN-1:0]         neg,
  input  logic [KW-1:0]         code,
  input  logic [LW-1:0]         code_len,
  output logic [FW-1:0]         field,
  output logic [LW-1:0]         total_len
);
  localparam int PAIR = TN / 2;

  int pos;

  always_comb begin
    field = {code, {TN{1'b0}}};
    pos   = int'(code_len);
    for (int i = 0; i < TN; i++) begin
      if ((quad || i < PAIR) && mag[i] != '0) begin
        field[FW-1-pos] = neg[i];
        pos = pos + 1;
      end
    end
    total_len = LW'(pos);
  end
endmodule

// File: rtl/stc_out_stage.sv
`timescale 1ns/1ps
module stc_out_stage #(
  parameter int FW = 20,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full,
  input  logic          over,
  input  logic [FW-1:0] field,
  input  logic [LW-1:0] len,
  input  logic          out_ready,
  output logic          take,
  output logic          out_valid,
  output logic [FW-1:0] out_bits,
  output logic [LW-1:0] out_len,
  output logic          err
);
  logic          v_q, v_d;
  logic          e_q, e_d;
  logic [FW-1:0] b_q;
  logic [LW-1:0] l_q;
  logic          load;

  always_comb begin
    take = full && (!v_q || out_ready);
    load = take && !over;
    e_d  = take && over;
    if (load)           v_d = 1'b1;
    else if (out_ready) v_d = 1'b0;
    else                v_d = v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      e_q <= 1'b0;
      b_q <= '0;
      l_q <= '0;
    end else begin
      v_q <= v_d;
      e_q <= e_d;
      if (load) begin
        b_q <= field;
        l_q <= len;
      end
    end
  end

  assign out_valid = v_q;
  assign out_bits  = b_q;
  assign out_len   = l_q;
  assign err       = e_q;

  // R8: a stalled word stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_len)));

  // R7: an error is a single-cycle pulse
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R6: length within the field and no stray bits below it
  a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0 && out_len <= LW'(FW) && (out_bits << out_len) == '0));
endmodule

// File: rtl/stc_tuple_coder.sv
`timescale 1ns/1ps
module stc_tuple_coder
  import stc_pkg::*;
#(
  parameter int CW = COEF_W,
  parameter int TN = TUPLE_MAX,
  parameter int MW = MAG_W,
  parameter int IW = IDX_W,
  parameter int KW = CODE_W,
  parameter int BW = BOOK_W,
  localparam int FW = KW + TN,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_coef,
  input  logic [BW-1:0] in_book,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_len,
  output logic [FW-1:0] out_bits,
  output logic          range_err
);
  logic [1:0]            rst_pipe;
  logic                  core_rst_n;

  logic                  take, full, t_over, quad;
  logic [BW-1:0]         t_book;
  logic [TN-1:0][MW-1:0] t_mag;
  logic [TN-1:0]         t_neg;
  logic [IW-1:0]         idx;
  logic [KW-1:0]         code;
  logic [LW-1:0]         code_len, total_len;
  logic [FW-1:0]         field;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  stc_tuple_asm #(.CW(CW), .TN(TN), .MW(MW), .BW(BW)) u_asm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_coef  (in_coef),
    .in_book  (in_book),
    .take     (take),
    .full     (full),
    .t_book   (t_book),
    .t_mag    (t_mag),
    .t_neg    (t_neg),
    .t_over   (t_over)
  );

  // table index from the held magnitudes
  always_comb begin
    quad = book_quad(t_book);
    idx  = '0;
    if (quad) begin
      for (int i = 0; i < TN; i++) idx[IW-1-i] = (t_mag[i] != '0);
    end else begin
      idx = IW'({t_mag[0], t_mag[1]});
    end
  end

  stc_codebook #(.BW(BW), .IW(IW), .KW(KW), .LW(LW)) u_book (
    .book     (t_book),
    .idx      (idx),
    .code     (code),
    .code_len (code_len)
  );

  stc_sign_merge #(.TN(TN), .MW(MW), .KW(KW), .LW(LW), .FW(FW)) u_merge (
    .quad      (quad),
    .mag       (t_mag),
    .neg       (t_neg),
    .code      (code),
    .code_len  (code_len),
    .field     (field),
    .total_len (total_len)
  );

  stc_out_stage #(.FW(FW), .LW(LW)) u_out (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .full      (full),
    .over      (t_over),
    .field     (field),
    .len       (total_len),
    .out_ready (out_ready),
    .take      (take),
    .out_valid (out_valid),
    .out_bits  (out_bits),
    .out_len   (out_len),
    .err       (range_err)
  );
endmodule

// File: tb/sim_stc_tuple_coder.sv
`timescale 1ns/1ps
module sim_stc_tuple_coder;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_coef;
  logic [1:0]  in_book;
  logic        out_valid;
  logic        out_ready;
  logic [4:0]  out_len;
  logic [19:0] out_bits;
  logic        range_err;

  stc_tuple_coder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_book(in_book), .out_valid(out_valid),
    .out_ready(out_ready), .out_len(out_len), .out_bits(out_bits),
    .range_err(range_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [25:0] exp_q[$];
  int  tb_cnt = 0;
  int  tb_book = 0;
  int  tb_c[4];
  bit  just_done = 0;
  bit  held = 0;
  logic [24:0] held_word;

  function automatic int tsize(int b);
    return (b >= 2) ? 2 : 4;
  endfunction

  // expected {err, len, bits} for one tuple, from the requirements
  function automatic logic [25:0] model(int b, int c0, int c1, int c2, int c3);
    int c[4];
    int n, lim, idx, len, m;
    logic [19:0] bits;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    n = tsize(b);
    lim = (b >= 2) ? 3 : 1;
    for (int i = 0; i < n; i++) begin
      m = (c[i] < 0) ? -c[i] : c[i];
      if (m > lim) return {1'b1, 25'd0};
    end
    if (n == 4) begin
      idx = 0;
      for (int i = 0; i < 4; i++) if (c[i] != 0) idx = idx + (1 << (3 - i));
    end else begin
      idx = ((c[0] < 0) ? -c[0] : c[0]) * 4 + ((c[1] < 0) ? -c[1] : c[1]);
    end
    bits = '0;
    len = 0;
    if (b % 2 == 0) begin
      for (int k = 0; k < idx; k++) begin bits[19 - len] = 1'b1; len++; end
      bits[19 - len] = 1'b0; len++;
    end else begin
      for (int k = 3; k >= 0; k--) begin bits[19 - len] = 1'((idx >> k) & 1); len++; end
    end
    for (int i = 0; i < n; i++) begin
      if (c[i] != 0) begin bits[19 - len] = (c[i] < 0); len++; end
    end
    return {1'b0, 5'(len), bits};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input bit v, input int coef, input int book, input bit ordy, output bit acc);
    logic [25:0] e;
    @(negedge clk);
    in_valid  = v;
    in_coef   = 8'(coef);
    in_book   = 2'(book);
    out_ready = ordy;
    #1;
    if (range_err) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected error pulse", 32'd1, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(e[25] == 1'b1, "R7 error pulse for in-range tuple", 32'd1, {31'd0, e[25]});
      end
    end
    if (held) begin
      chk(out_valid && {out_len, out_bits} == held_word, "R8 stalled word changed",
          {6'd0, out_valid, out_len, out_bits}, {7'd1, held_word});
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 output word for no pending tuple", {7'd0, out_len, out_bits}, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(e[25] == 1'b0 && e[24:0] == {out_len, out_bits}, "R1 R2 R3 R4 R5 R6 output word",
            {7'd0, out_len, out_bits}, {6'd0, e});
      end
    end
    held = out_valid && !out_ready;
    held_word = {out_len, out_bits};
    if (just_done) begin
      chk(in_ready == 1'b0, "R9 ready after tuple end", {31'd0, in_ready}, 32'd0);
      just_done = 0;
    end
    acc = v && in_ready;
    if (acc) begin
      if (tb_cnt == 0) tb_book = book;
      tb_c[tb_cnt] = coef;
      tb_cnt++;
      if (tb_cnt == tsize(tb_book)) begin
        exp_q.push_back(model(tb_book, tb_c[0], tb_c[1], tb_c[2], tb_c[3]));
        tb_cnt = 0;
        just_done = 1;
      end
    end
  endtask

  // R1: alt is driven on in_book for all coefficients after the first
  task automatic send(input int b, input int c0, input int c1, input int c2, input int c3, input int alt);
    int c[4];
    bit acc;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    for (int i = 0; i < tsize(b); i++) begin
      acc = 0;
      while (!acc) step(1'b1, c[i], (i == 0) ? b : alt, 1'b1, acc);
    end
  endtask

  function automatic int gen_coef(int b);
    int r, lim, m;
    lim = (b >= 2) ? 3 : 1;
    r = int'($urandom % 32);
    if (r == 0) return -128;
    if (r < 3) m = lim + 1 + int'($urandom % 3);
    else       m = int'($urandom % (lim + 1));
    return ($urandom % 2 == 1) ? -m : m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    int b, cv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_coef = '0;
    in_book = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk(range_err == 1'b0, "R9 reset range_err", {31'd0, range_err}, 32'd0);
    chk(in_ready == 1'b1, "R9 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    send(0, 0, 0, 0, 0, 3);       // R2 R3: index 0, single zero bit
    send(0, 1, -1, 0, -1, 2);     // R5: signs in position order
    send(0, -1, -1, -1, -1, 1);   // R6: 16-bit code plus four signs, full field
    send(1, -1, -1, -1, -1, 2);   // R4: flat book, index 15
    send(2, 3, -3, 0, 0, 0);      // R1: later book ignored, pair stays a pair
    send(3, 0, -2, 0, 0, 1);      // R4 R5
    send(2, 4, 0, 0, 0, 2);       // R7: one above the limit
    send(0, 1, 0, 0, 2, 0);       // R7: overflow in last position
    send(3, -128, 0, 0, 0, 3);    // R7: most negative value
    send(2, 0, 0, 0, 0, 1);       // R1 R7: clean tuple right after errors
    send(1, 0, 1, 0, 0, 3);

    // back-pressure on a waiting word
    for (int k = 0; k < 6; k++) step(1'b0, 0, 0, 1'b0, acc);
    send(2, -1, 2, 0, 0, 0);
    for (int k = 0; k < 8; k++) step(1'b0, 0, 0, 1'b0, acc);
    for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 1'b1, acc);

    // constrained random
    for (int t = 0; t < 600; t++) begin
      b = int'($urandom % 4);
      for (int i = 0; i < tsize(b); i++) begin
        cv = gen_coef(b);
        acc = 0;
        while (!acc)
          step(($urandom % 4) != 0, cv, (i == 0) ? b : int'($urandom % 4), ($urandom % 10) < 7, acc);
      end
    end

    for (int k = 0; k < 30; k++) step(1'b0, 0, 0, 1'b1, acc);
    chk(exp_q.size() == 0, "R6 R7 tuples left without output", exp_q.size(), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule